// File: doc/BRIEF.md
# Remote Reconfiguration Boot Sequencer

This block runs once after reset and steers the on-chip remote-configuration controller so that a device which came up cleanly in its factory image relaunches into the application image. It first waits for the controller to report ready. It then waits a long settling time before it reads the reconfiguration trigger status. A read issued too early comes back with every cause bit set and would wrongly look like a failure history.

A zero trigger status means a normal power-up. In that case the sequencer writes four controller parameters in a fixed order and then raises a reconfiguration request for a minimum time. It also starts a periodic watchdog refresh as soon as the watchdog has been turned on. A nonzero status means the device is already running the factory image after a fault. In that case the sequencer does nothing further and parks for good.

All controller traffic goes through one parameter port with a strobe-and-busy handshake. The settling time, the request length and the refresh interval are derived from a clock-frequency parameter, rounded up to whole cycles.

Top module: `cfg_boot_sequencer`

## Requirements
- R1: `core_rst` is 1 while `rst_n` is 0. It is 0 from the first clock edge after `rst_n` is released, and it stays 0.
- R2: No read or write strobe is raised until `core_busy` has been seen low at least once since reset.
- R3: Exactly one read is issued, with code 3'b000. It starts no fewer than ceil(SETTLE_US*CLK_FREQ_HZ/1e6) cycles after `core_busy` is first seen low. `trig_status` takes `par_rdata[4:0]` of that read, captured when busy falls.
- R4: A strobe is held until `core_busy` rises and is then dropped. The next access starts only after `core_busy` has fallen. `par_rd` and `par_wr` are never high together.
- R5: With a zero trigger status, exactly four writes follow, in this order: code 3'b010 with data WD_TIMEOUT, code 3'b011 with data 1 (watchdog on), code 3'b001 with data 1 (application mode), and code 3'b100 with data APP_ADDR.
- R6: After the fourth write completes, `reconfig` is high for exactly ceil(PULSE_NS*CLK_FREQ_HZ/1e9) consecutive cycles, once only. `seq_launched` then rises and stays high.
- R7: With a nonzero trigger status, no write is issued and `reconfig` never rises. `seq_parked` rises and stays high.
- R8: `wd_kick` produces one-cycle pulses spaced exactly KICK_CYC cycles apart. The first pulse comes only after the watchdog-enable write has been issued. No pulse occurs on the parked path.
- R9: During and straight after reset, `par_rd`, `par_wr`, `reconfig`, `wd_kick`, `seq_launched` and `seq_parked` are 0 and `trig_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_rst | output | 1 | Active-high reset to the configuration controller |
| core_busy | input | 1 | Controller busy flag |
| par_rd | output | 1 | Parameter read strobe |
| par_wr | output | 1 | Parameter write strobe |
| par_code | output | 3 | Parameter select code |
| par_wdata | output | 32 | Parameter write data |
| par_rdata | input | 32 | Parameter read data |
| reconfig | output | 1 | Reconfiguration request |
| wd_kick | output | 1 | Watchdog refresh pulse |
| trig_status | output | 5 | Captured trigger cause bits |
| seq_launched | output | 1 | Application launch sequence finished |
| seq_parked | output | 1 | Nonzero cause seen, sequencer idle |

## Verification
A sequencer stuck in the wrong state shows up on the parameter port within a few cycles of the faulty transition. The symptoms are a strobe while the controller is busy, a missing or extra write, or writes in the wrong order. A shortened settling count shows up at once as a read that the controller model answers with all cause bits set, which sends the block down the parked path. Counter faults in the request or refresh timers show up as a wrong pulse width, or as a wrong spacing between refresh pulses, within one interval of launch.

// File: rtl/cbs_pkg.sv
// Shared types for the boot sequencer.
// Assumes a 32-bit parameter data bus and a 3-bit parameter code.
package cbs_pkg;
    localparam int          PAR_DW    = 32;
    localparam int          TRIG_W    = 5;
    localparam logic [2:0]  CODE_TRIG = 3'b000;

    typedef enum logic [3:0] {
        ST_WAIT_RDY,
        ST_SETTLE,
        ST_READ,
        ST_WAIT_RD,
        ST_DECIDE,
        ST_WRITE,
        ST_WAIT_WR,
        ST_PULSE,
        ST_LAUNCHED,
        ST_PARKED
    } seq_state_t;

    typedef enum logic [1:0] {
        PP_IDLE,
        PP_REQ,
        PP_WAIT
    } port_state_t;

    typedef struct packed {
        logic [2:0]        code;
        logic [PAR_DW-1:0] data;
    } par_req_t;
endpackage

// File: rtl/cbs_countdown.sv
// Loadable down-counter. It flags zero when it reaches the end of its count.
// Assumes the loaded value is the number of cycles minus one.
module cbs_countdown #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Count down from the loaded value and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cbs_param_port.sv
// Runs one parameter access at a time over the strobe/busy handshake.
// Raises the strobe, holds it until busy rises, then waits for busy to fall.
// Captures the read data and pulses done at the point where busy falls.
// Assumes start is raised only while the port is idle.
module cbs_param_port
    import cbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  par_req_t          start_req,
    input  logic              core_busy,
    input  logic [PAR_DW-1:0] par_rdata,
    output logic              par_rd,
    output logic              par_wr,
    output logic [2:0]        par_code,
    output logic [PAR_DW-1:0] par_wdata,
    output logic [PAR_DW-1:0] rd_data,
    output logic              done
);
    port_state_t st;
    logic        is_rd;

    // Handshake sequencing and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= PP_IDLE;
            is_rd     <= 1'b0;
            par_rd    <= 1'b0;
            par_wr    <= 1'b0;
            par_code  <= '0;
            par_wdata <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                PP_IDLE: if (start) begin
                    st        <= PP_REQ;
                    is_rd     <= start_rd;
                    par_rd    <= start_rd;
                    par_wr    <= ~start_rd;
                    par_code  <= start_req.code;
                    par_wdata <= start_req.data;
                end
                PP_REQ: if (core_busy) begin
                    st     <= PP_WAIT;
                    par_rd <= 1'b0;
                    par_wr <= 1'b0;
                end
                PP_WAIT: if (!core_busy) begin
                    st   <= PP_IDLE;
                    done <= 1'b1;
                    if (is_rd) rd_data <= par_rdata;
                end
                default: st <= PP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cbs_wd_kicker.sv
// Periodic watchdog refresh generator.
// Once armed, it emits a one-cycle pulse every INTERVAL cycles.
// Assumes INTERVAL is shorter than the programmed watchdog timeout.
module cbs_wd_kicker #(
    parameter int INTERVAL = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic kick
);
    localparam int W = $clog2(INTERVAL + 1);
    logic [W-1:0] cnt;

    // Reload the interval while disarmed, then count and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            cnt  <= W'(INTERVAL - 1);
            kick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= W'(INTERVAL - 1);
            kick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            kick <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_boot_sequencer.sv
// One-shot boot sequencer for the remote-configuration controller.
// It waits for the controller to be ready, lets it settle, and reads the trigger causes.
// On a clean power-up it writes the launch parameters and raises the reconfiguration request.
// Otherwise it parks. Assumes the controller answers every strobe with a busy pulse.
module cfg_boot_sequencer
    import cbs_pkg::*;
#(
    parameter longint      CLK_FREQ_HZ = 100_000_000,
    parameter longint      SETTLE_US   = 1000,
    parameter longint      PULSE_NS    = 250,
    parameter int          KICK_CYC    = 50_000,
    parameter logic [31:0] WD_TIMEOUT  = 32'h0000_0FFF,
    parameter logic [31:0] APP_ADDR    = 32'h0100_0000,
    parameter logic [2:0]  CODE_WD_TMO = 3'b010,
    parameter logic [2:0]  CODE_WD_EN  = 3'b011,
    parameter logic [2:0]  CODE_MODE   = 3'b001,
    parameter logic [2:0]  CODE_ADDR   = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              core_rst,
    input  logic              core_busy,
    output logic              par_rd,
    output logic              par_wr,
    output logic [2:0]        par_code,
    output logic [PAR_DW-1:0] par_wdata,
    input  logic [PAR_DW-1:0] par_rdata,
    output logic              reconfig,
    output logic              wd_kick,
    output logic [TRIG_W-1:0] trig_status,
    output logic              seq_launched,
    output logic              seq_parked
);
    localparam longint SETTLE_CYC = (SETTLE_US * CLK_FREQ_HZ + 999_999) / 1_000_000;
    localparam longint PULSE_CYC  = (PULSE_NS * CLK_FREQ_HZ + 999_999_999) / 1_000_000_000;
    localparam longint MAX_CYC    = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int     TMR_W      = $clog2(MAX_CYC + 1);
    localparam int     N_WR       = 4;

    seq_state_t        state, state_n;
    logic [1:0]        wr_idx;
    logic              wd_armed;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              pp_start, pp_rd, pp_done;
    par_req_t          pp_req;
    logic [PAR_DW-1:0] pp_rdata;
    logic [TRIG_W-1:0] trig_q;
    logic              core_rst_q, reconfig_q, launched_q, parked_q;

    // Launch write table, indexed by write step.
    function automatic par_req_t wr_entry(input logic [1:0] idx);
        case (idx)
            2'd0:    wr_entry = '{code: CODE_WD_TMO, data: WD_TIMEOUT};
            2'd1:    wr_entry = '{code: CODE_WD_EN,  data: 32'd1};
            2'd2:    wr_entry = '{code: CODE_MODE,   data: 32'd1};
            default: wr_entry = '{code: CODE_ADDR,   data: APP_ADDR};
        endcase
    endfunction

    // Next-state and command decode.
    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pp_start = 1'b0;
        pp_rd    = 1'b0;
        pp_req   = '{code: CODE_TRIG, data: '0};
        case (state)
            ST_WAIT_RDY: if (!core_busy) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SETTLE_CYC - 1);
                state_n  = ST_SETTLE;
            end
            ST_SETTLE:  if (tmr_zero) state_n = ST_READ;
            ST_READ: begin
                pp_start = 1'b1;
                pp_rd    = 1'b1;
                state_n  = ST_WAIT_RD;
            end
            ST_WAIT_RD: if (pp_done) state_n = ST_DECIDE;
            ST_DECIDE:  state_n = (trig_q == '0) ? ST_WRITE : ST_PARKED;
            ST_WRITE: begin
                pp_start = 1'b1;
                pp_req   = wr_entry(wr_idx);
                state_n  = ST_WAIT_WR;
            end
            ST_WAIT_WR: if (pp_done) begin
                if (wr_idx == 2'(N_WR - 1)) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(PULSE_CYC - 1);
                    state_n  = ST_PULSE;
                end else begin
                    state_n  = ST_WRITE;
                end
            end
            ST_PULSE:    if (tmr_zero) state_n = ST_LAUNCHED;
            ST_LAUNCHED: state_n = ST_LAUNCHED;
            ST_PARKED:   state_n = ST_PARKED;
            default:     state_n = ST_PARKED;
        endcase
    end

    // State, step index, captured status and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT_RDY;
            wr_idx     <= '0;
            wd_armed   <= 1'b0;
            trig_q     <= '0;
            core_rst_q <= 1'b1;
            reconfig_q <= 1'b0;
            launched_q <= 1'b0;
            parked_q   <= 1'b0;
        end else begin
            state      <= state_n;
            core_rst_q <= 1'b0;
            reconfig_q <= (state_n == ST_PULSE);
            launched_q <= (state_n == ST_LAUNCHED);
            parked_q   <= (state_n == ST_PARKED);
            if (state == ST_WAIT_RD && pp_done)
                trig_q <= pp_rdata[TRIG_W-1:0];
            if (state == ST_WAIT_WR && pp_done) begin
                if (wr_idx == 2'd1) wd_armed <= 1'b1;
                if (wr_idx != 2'(N_WR - 1)) wr_idx <= wr_idx + 1'b1;
            end
        end
    end

    cbs_countdown #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cbs_param_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pp_start),
        .start_rd  (pp_rd),
        .start_req (pp_req),
        .core_busy (core_busy),
        .par_rdata (par_rdata),
        .par_rd    (par_rd),
        .par_wr    (par_wr),
        .par_code  (par_code),
        .par_wdata (par_wdata),
        .rd_data   (pp_rdata),
        .done      (pp_done)
    );

    cbs_wd_kicker #(.INTERVAL(KICK_CYC)) u_kick (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (wd_armed),
        .kick  (wd_kick)
    );

    assign core_rst     = core_rst_q;
    assign reconfig     = reconfig_q;
    assign trig_status  = trig_q;
    assign seq_launched = launched_q;
    assign seq_parked   = parked_q;
endmodule

// File: rtl/cfg_boot_sequencer_chk.sv
// Port-level protocol checks for the boot sequencer, attached by bind.
module cfg_boot_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_rst,
    input logic       core_busy,
    input logic       par_rd,
    input logic       par_wr,
    input logic       reconfig,
    input logic       wd_kick,
    input logic [4:0] trig_status,
    input logic       seq_launched,
    input logic       seq_parked
);
    logic seen_ready;

    // Track whether busy has been low since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          seen_ready <= 1'b0;
        else if (!core_busy) seen_ready <= 1'b1;
    end

    assert_rst_held_R1: assert property (@(posedge clk) !rst_n |=> core_rst);
    assert_rst_low_R1: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> !core_rst);
    assert_no_early_access_R2: assert property (@(posedge clk) disable iff (!rst_n) (par_rd || par_wr) |-> seen_ready);
    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n) !(par_rd && par_wr));
    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n) (par_rd && !core_busy) |=> par_rd);
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n) (par_wr && !core_busy) |=> par_wr);
    assert_reconfig_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n) reconfig |-> !(par_rd || par_wr));
    assert_reconfig_clean_R6: assert property (@(posedge clk) disable iff (!rst_n) reconfig |-> (trig_status == 5'd0));
    assert_launch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n) seq_launched |=> seq_launched);
    assert_park_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n) seq_parked |=> seq_parked);
    assert_park_cause_R7: assert property (@(posedge clk) disable iff (!rst_n) seq_parked |-> (trig_status != 5'd0 && !reconfig));
    assert_kick_path_R8: assert property (@(posedge clk) disable iff (!rst_n) wd_kick |-> (!seq_parked && trig_status == 5'd0));
    assert_kick_single_R8: assert property (@(posedge clk) disable iff (!rst_n) wd_kick |=> !wd_kick);
endmodule

bind cfg_boot_sequencer cfg_boot_sequencer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_rst     (core_rst),
    .core_busy    (core_busy),
    .par_rd       (par_rd),
    .par_wr       (par_wr),
    .reconfig     (reconfig),
    .wd_kick      (wd_kick),
    .trig_status  (trig_status),
    .seq_launched (seq_launched),
    .seq_parked   (seq_parked)
);

// File: tb/cfg_boot_sequencer_tb.sv
// Directed bench. A behavioural controller model answers strobes with busy.
// The model returns all cause bits set to any read issued before the settling time.
module cfg_boot_sequencer_tb;
    localparam int          SETTLE   = 400;   // 2 us at 200 MHz
    localparam int          PULSE    = 50;    // 250 ns at 200 MHz
    localparam int          KICK     = 37;
    localparam int          PWR      = 20;
    localparam logic [31:0] TMO      = 32'h0000_0ABC;
    localparam logic [31:0] ADDR     = 32'h0120_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_rst, core_busy, par_rd, par_wr, reconfig, wd_kick;
    logic        seq_launched, seq_parked;
    logic [2:0]  par_code;
    logic [31:0] par_wdata, par_rdata;
    logic [4:0]  trig_status;
    logic [4:0]  trig_val = 5'd0;

    int checks = 0, fails = 0, cyc = 0;

    always #2.5 clk = ~clk;

    cfg_boot_sequencer #(
        .CLK_FREQ_HZ (200_000_000),
        .SETTLE_US   (2),
        .PULSE_NS    (250),
        .KICK_CYC    (KICK),
        .WD_TIMEOUT  (TMO),
        .APP_ADDR    (ADDR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .core_busy(core_busy),
        .par_rd(par_rd), .par_wr(par_wr), .par_code(par_code), .par_wdata(par_wdata),
        .par_rdata(par_rdata), .reconfig(reconfig), .wd_kick(wd_kick),
        .trig_status(trig_status), .seq_launched(seq_launched), .seq_parked(seq_parked)
    );

    // Controller model and traffic log.
    int pwr, bcnt, age, nlog, nread, read_age, early, both;
    logic [2:0]  read_code;
    logic [2:0]  lcode [8];
    logic [31:0] ldata [8];
    int          lcyc  [8];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            core_busy <= 1'b1; par_rdata <= '0;
            pwr <= PWR; bcnt <= 0; age <= 0; nlog <= 0; nread <= 0;
            read_age <= -1; early <= 0; both <= 0; read_code <= 3'b111;
        end else begin
            if (par_rd && par_wr) both <= both + 1;
            if (pwr > 0) begin
                if (par_rd || par_wr) early <= early + 1;
                if (pwr == 1) core_busy <= 1'b0;
                pwr <= pwr - 1;
            end else begin
                if (age < 1000000) age <= age + 1;
                if (bcnt > 0) begin
                    if (bcnt == 1) core_busy <= 1'b0;
                    bcnt <= bcnt - 1;
                end else if ((par_rd || par_wr) && !core_busy) begin
                    core_busy <= 1'b1;
                    bcnt <= 3;
                    if (par_rd) begin
                        nread <= nread + 1; read_age <= age; read_code <= par_code;
                        par_rdata <= (age < SETTLE) ? 32'hABCD_001F : {27'h5A5A5A5, trig_val};
                    end else if (nlog < 8) begin
                        lcode[nlog] <= par_code; ldata[nlog] <= par_wdata;
                        lcyc[nlog] <= cyc; nlog <= nlog + 1;
                    end
                end
            end
        end
    end

    // Pulse and refresh monitors.
    int npulse, pwidth, wr_at_pulse, nkick, first_kick, last_kick, bad_gap;
    logic prev_rc;
    always @(posedge clk) begin
        if (!rst_n) begin
            npulse <= 0; pwidth <= 0; wr_at_pulse <= -1; prev_rc <= 1'b0;
            nkick <= 0; first_kick <= -1; last_kick <= 0; bad_gap <= 0;
        end else begin
            prev_rc <= reconfig;
            if (reconfig) begin
                pwidth <= pwidth + 1;
                if (!prev_rc) begin npulse <= npulse + 1; wr_at_pulse <= nlog; end
            end
            if (wd_kick) begin
                nkick <= nkick + 1;
                if (nkick == 0) first_kick <= cyc;
                else if (cyc - last_kick != KICK) bad_gap <= bad_gap + 1;
                last_kick <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] t);
        @(negedge clk);
        trig_val = t;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        trig_val = 5'd0;
        repeat (4) @(negedge clk);
        chk(core_rst == 1'b1, "R1 core_rst in reset", core_rst, 1);
        chk({par_rd, par_wr, reconfig, wd_kick, seq_launched, seq_parked} == 6'b0,
            "R9 outputs in reset", {par_rd, par_wr, reconfig, wd_kick, seq_launched, seq_parked}, 0);
        chk(trig_status == 5'd0, "R9 trig_status in reset", trig_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_rst == 1'b0, "R1 core_rst released", core_rst, 0);
        chk({par_rd, par_wr, seq_launched, seq_parked} == 4'b0,
            "R9 idle after release", {par_rd, par_wr, seq_launched, seq_parked}, 0);
    endtask

    task automatic test_launch();
        do_reset(5'd0);
        for (int i = 0; i < 3000 && !seq_launched; i++) @(negedge clk);
        repeat (200) @(negedge clk);
        chk(core_rst == 1'b0, "R1 core_rst stays low", core_rst, 0);
        chk(early == 0, "R2 access during power-up busy", early, 0);
        chk(nread == 1, "R3 read count", nread, 1);
        chk(read_code == 3'b000, "R3 read code", read_code, 0);
        chk(read_age >= SETTLE, "R3 settle before read", read_age, SETTLE);
        chk(trig_status == 5'd0, "R3 captured status", trig_status, 0);
        chk(both == 0, "R4 rd and wr together", both, 0);
        chk(nlog == 4, "R5 write count", nlog, 4);
        chk(lcode[0] == 3'b010 && ldata[0] == TMO, "R5 write 0", {lcode[0], ldata[0]}, {3'b010, TMO});
        chk(lcode[1] == 3'b011 && ldata[1] == 32'd1, "R5 write 1", {lcode[1], ldata[1]}, {3'b011, 32'd1});
        chk(lcode[2] == 3'b001 && ldata[2] == 32'd1, "R5 write 2", {lcode[2], ldata[2]}, {3'b001, 32'd1});
        chk(lcode[3] == 3'b100 && ldata[3] == ADDR, "R5 write 3", {lcode[3], ldata[3]}, {3'b100, ADDR});
        chk(npulse == 1, "R6 request pulses", npulse, 1);
        chk(pwidth == PULSE, "R6 request width", pwidth, PULSE);
        chk(wr_at_pulse == 4, "R6 writes before request", wr_at_pulse, 4);
        chk(seq_launched && !seq_parked, "R6 launched flag", {seq_launched, seq_parked}, 2'b10);
        chk(nkick >= 3, "R8 refresh pulses seen", nkick, 3);
        chk(first_kick > lcyc[1], "R8 refresh after enable", first_kick, lcyc[1]);
        chk(bad_gap == 0, "R8 refresh spacing", bad_gap, 0);
    endtask

    task automatic test_parked(input logic [4:0] t);
        do_reset(t);
        for (int i = 0; i < 3000 && !seq_parked; i++) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(trig_status == t, "R3 captured cause", trig_status, t);
        chk(read_age >= SETTLE, "R3 settle before read (parked)", read_age, SETTLE);
        chk(nlog == 0, "R7 no writes", nlog, 0);
        chk(npulse == 0, "R7 no request", npulse, 0);
        chk(seq_parked && !seq_launched, "R7 parked flag", {seq_launched, seq_parked}, 2'b01);
        chk(nkick == 0, "R8 no refresh when parked", nkick, 0);
    endtask

    initial begin
        test_reset_state();
        test_launch();
        test_parked(5'h12);
        test_parked(5'h01);
        test_parked(5'h1F);
        test_launch();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule